// File: doc/BRIEF.md
# Two-Threshold Programmable Coincidence Array

This block decides, in a single combinational pass, whether hits on two sets of detector strips line up according to a programmable pattern. The X side is 8 positions wide and is fed by two input groups. The Y side is 24 positions wide and is fed by three input groups. Each input bit first goes through its own mask, which can pin the bit to a common level. Each axis position is then reduced to two signals: "at least one hit" and "at least two hits". Each of the 8-by-24 crossing points combines these signals into a three-of-four style majority decision. That decision is gated by two stored coefficient bits, one per threshold. The gated decisions are ORed down each X column.

The two column vectors give two summary flags. They also give a position vector, which reports the threshold-2 columns whenever any of them fired and the threshold-1 columns otherwise. Coefficients are loaded a row pattern at a time: one X-wide pattern per bit, written into every row picked by a row-select vector. They can be read back by capturing the two column vectors into holding registers. A small operation decoder resolves each clock into one of three operations: OP_IDLE (nothing), OP_WRITE (coefficient load) and OP_READ (column capture). A write request wins over a read request in the same cycle.

Top module: `coinc_array`

## Requirements
- R1: For every input bit, a mask bit of 1 replaces the input with `mask_level` before counting; a mask bit of 0 passes the input unchanged.
- R2: For each X position, the count of hits over the two X groups gives x_ge1 (count ≥ 1) and x_ge2 (count ≥ 2). For each Y position, the count over the three Y groups gives y_ge1 and y_ge2 in the same way.
- R3: Crossing point (i, j) fires when (x_ge2[i] AND y_ge1[j]) OR (x_ge1[i] AND y_ge2[j]).
- R4: Each cell holds a two-bit code {C1,C0}: 00 means no threshold, 01 means threshold 1, 10 means threshold 2, 11 means both. Threshold-1 column i is the OR over rows j of fire(i,j) AND C0(i,j). Threshold-2 column i is formed the same way with C1.
- R5: `thr1` is the OR of the 8 threshold-1 columns and `thr2` is the OR of the threshold-2 columns. Both may be high together.
- R6: `xpos` equals the threshold-2 column vector when any threshold-2 column is set, and the threshold-1 column vector otherwise. It is zero when neither threshold fired.
- R7: When `coef_wr` is high at a rising edge, every row j with `coef_row_sel[j]`=1 is loaded with C0[i]=`coef_c0_col[i]` and C1[i]=`coef_c1_col[i]`. Rows with select 0 keep their codes, and `coef_row_sel`=0 changes nothing.
- R8: When `coef_rd` is high (and `coef_wr` low) at a rising edge, `rd_th1` and `rd_th2` capture the threshold-1 and threshold-2 column vectors. Otherwise they hold their values. With all X bits at two hits and exactly Y row j at one hit, the capture returns row j's C0 and C1.
- R9: When `coef_wr` and `coef_rd` are both high in one cycle, only the write is performed and the capture registers keep their values.
- R10: After reset, every coefficient is 00 and `rd_th1`/`rd_th2` are 0.
- R11: `thr1`, `thr2` and `xpos` follow input changes in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for coefficient and capture registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_level | input | 1 | Level forced onto masked input bits |
| xa_in | input | 8 | X input group A |
| xb_in | input | 8 | X input group B |
| ya_in | input | 24 | Y input group A |
| yb_in | input | 24 | Y input group B |
| yc_in | input | 24 | Y input group C |
| xa_mask | input | 8 | Mask for X group A |
| xb_mask | input | 8 | Mask for X group B |
| ya_mask | input | 24 | Mask for Y group A |
| yb_mask | input | 24 | Mask for Y group B |
| yc_mask | input | 24 | Mask for Y group C |
| coef_wr | input | 1 | Coefficient write request |
| coef_row_sel | input | 24 | Rows loaded by a write |
| coef_c0_col | input | 8 | Threshold-1 coefficient pattern per column |
| coef_c1_col | input | 8 | Threshold-2 coefficient pattern per column |
| coef_rd | input | 1 | Column capture request |
| thr1 | output | 1 | Threshold 1 satisfied somewhere |
| thr2 | output | 1 | Threshold 2 satisfied somewhere |
| xpos | output | 8 | Column vector of the preferred threshold |
| rd_th1 | output | 8 | Captured threshold-1 column vector |
| rd_th2 | output | 8 | Captured threshold-2 column vector |

## Verification
The assertions assume that `coef_wr`, `coef_rd` and the coefficient pattern inputs are steady at each rising edge. The bench meets this by driving every input only just after a falling edge. The capture and row-load properties also assume that the inputs do not glitch around the sampling edge. The random phase draws sparse Y patterns and random masks and coefficient rows. Directed cases cover the hit-count boundaries, both thresholds firing at once, write-read collision, an empty row select, and masking to 1.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    typedef struct packed {
        logic c1;
        logic c0;
    } coef_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

endpackage

// File: rtl/coinc_axis_prep.sv
module coinc_axis_prep #(
    parameter int W  = 8,
    parameter int NG = 2
) (
    input  logic                   mask_level,
    input  logic [NG-1:0][W-1:0]   grp_in,
    input  logic [NG-1:0][W-1:0]   grp_mask,
    output logic [W-1:0]           ge1,
    output logic [W-1:0]           ge2
);
    localparam int CW = $clog2(NG + 1);

    logic [NG-1:0][W-1:0] masked;

    // per-bit masking of every group
    genvar g;
    generate
        for (g = 0; g < NG; g++) begin : g_mask
            assign masked[g] = (grp_in[g] & ~grp_mask[g]) |
                               ({W{mask_level}} & grp_mask[g]);
        end
    endgenerate

    // hit count per position reduced to two thresholds
    always_comb begin
        logic [CW-1:0] cnt;
        for (int b = 0; b < W; b++) begin
            cnt = '0;
            for (int k = 0; k < NG; k++) begin
                cnt = cnt + CW'(masked[k][b]);
            end
            ge1[b] = (cnt >= CW'(1));
            ge2[b] = (cnt >= CW'(2));
        end
    end

endmodule

// File: rtl/coinc_matrix.sv
module coinc_matrix
    import coinc_pkg::*;
#(
    parameter int NX = 8,
    parameter int NY = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NX-1:0]     x_ge1,
    input  logic [NX-1:0]     x_ge2,
    input  logic [NY-1:0]     y_ge1,
    input  logic [NY-1:0]     y_ge2,
    input  logic              wr_en,
    input  logic [NY-1:0]     wr_row,
    input  logic [NX-1:0]     wr_c0,
    input  logic [NX-1:0]     wr_c1,
    output logic [NX-1:0]     col_th1,
    output logic [NX-1:0]     col_th2
);
    coef_t [NY-1:0][NX-1:0] cell_q;
    logic  [NY-1:0][NX-1:0] hit_t1;
    logic  [NY-1:0][NX-1:0] hit_t2;

    genvar r, c;
    generate
        for (r = 0; r < NY; r++) begin : g_row
            // row-masked coefficient store
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q[r] <= '0;
                end else if (wr_en && wr_row[r]) begin
                    for (int i = 0; i < NX; i++) begin
                        cell_q[r][i].c0 <= wr_c0[i];
                        cell_q[r][i].c1 <= wr_c1[i];
                    end
                end
            end

            for (c = 0; c < NX; c++) begin : g_col
                logic fire;
                assign fire         = (x_ge2[c] & y_ge1[r]) | (x_ge1[c] & y_ge2[r]);
                assign hit_t1[r][c] = fire & cell_q[r][c].c0;
                assign hit_t2[r][c] = fire & cell_q[r][c].c1;
            end
        end
    endgenerate

    // OR down each column
    always_comb begin
        col_th1 = '0;
        col_th2 = '0;
        for (int j = 0; j < NY; j++) begin
            col_th1 = col_th1 | hit_t1[j];
            col_th2 = col_th2 | hit_t2[j];
        end
    end

endmodule

// File: rtl/coinc_thr_select.sv
module coinc_thr_select #(
    parameter int NX = 8
) (
    input  logic [NX-1:0] col_th1,
    input  logic [NX-1:0] col_th2,
    output logic          thr1,
    output logic          thr2,
    output logic [NX-1:0] xpos
);
    always_comb begin
        thr1 = |col_th1;
        thr2 = |col_th2;
        xpos = thr2 ? col_th2 : col_th1;
    end

endmodule

// File: rtl/coinc_ctrl.sv
module coinc_ctrl
    import coinc_pkg::*;
#(
    parameter int NX = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [NX-1:0] col_th1,
    input  logic [NX-1:0] col_th2,
    output logic          wr_en,
    output logic [NX-1:0] z_th1,
    output logic [NX-1:0] z_th2
);
    op_e op;

    // operation decode: write outranks read
    always_comb begin
        if (wr_req)      op = OP_WRITE;
        else if (rd_req) op = OP_READ;
        else             op = OP_IDLE;
    end

    always_comb begin
        unique case (op)
            OP_WRITE: wr_en = 1'b1;
            OP_READ:  wr_en = 1'b0;
            OP_IDLE:  wr_en = 1'b0;
            default:  wr_en = 1'b0;
        endcase
    end

    // capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z_th1 <= '0;
            z_th2 <= '0;
        end else begin
            unique case (op)
                OP_READ: begin
                    z_th1 <= col_th1;
                    z_th2 <= col_th2;
                end
                OP_WRITE, OP_IDLE: begin
                    z_th1 <= z_th1;
                    z_th2 <= z_th2;
                end
                default: begin
                    z_th1 <= z_th1;
                    z_th2 <= z_th2;
                end
            endcase
        end
    end

endmodule

// File: rtl/coinc_array.sv
module coinc_array
    import coinc_pkg::*;
#(
    parameter int NX = 8,
    parameter int NY = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_level,
    input  logic [NX-1:0] xa_in,
    input  logic [NX-1:0] xb_in,
    input  logic [NY-1:0] ya_in,
    input  logic [NY-1:0] yb_in,
    input  logic [NY-1:0] yc_in,
    input  logic [NX-1:0] xa_mask,
    input  logic [NX-1:0] xb_mask,
    input  logic [NY-1:0] ya_mask,
    input  logic [NY-1:0] yb_mask,
    input  logic [NY-1:0] yc_mask,
    input  logic          coef_wr,
    input  logic [NY-1:0] coef_row_sel,
    input  logic [NX-1:0] coef_c0_col,
    input  logic [NX-1:0] coef_c1_col,
    input  logic          coef_rd,
    output logic          thr1,
    output logic          thr2,
    output logic [NX-1:0] xpos,
    output logic [NX-1:0] rd_th1,
    output logic [NX-1:0] rd_th2
);
    localparam int XG = 2;
    localparam int YG = 3;

    logic [XG-1:0][NX-1:0] x_grp, x_msk;
    logic [YG-1:0][NY-1:0] y_grp, y_msk;
    logic [NX-1:0] x_ge1, x_ge2;
    logic [NY-1:0] y_ge1, y_ge2;
    logic [NX-1:0] col_th1, col_th2;
    logic          wr_en;

    assign x_grp = {xb_in, xa_in};
    assign x_msk = {xb_mask, xa_mask};
    assign y_grp = {yc_in, yb_in, ya_in};
    assign y_msk = {yc_mask, yb_mask, ya_mask};

    coinc_axis_prep #(.W(NX), .NG(XG)) u_xprep (
        .mask_level (mask_level),
        .grp_in     (x_grp),
        .grp_mask   (x_msk),
        .ge1        (x_ge1),
        .ge2        (x_ge2)
    );

    coinc_axis_prep #(.W(NY), .NG(YG)) u_yprep (
        .mask_level (mask_level),
        .grp_in     (y_grp),
        .grp_mask   (y_msk),
        .ge1        (y_ge1),
        .ge2        (y_ge2)
    );

    coinc_ctrl #(.NX(NX)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (coef_wr),
        .rd_req  (coef_rd),
        .col_th1 (col_th1),
        .col_th2 (col_th2),
        .wr_en   (wr_en),
        .z_th1   (rd_th1),
        .z_th2   (rd_th2)
    );

    coinc_matrix #(.NX(NX), .NY(NY)) u_mat (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_ge1   (x_ge1),
        .x_ge2   (x_ge2),
        .y_ge1   (y_ge1),
        .y_ge2   (y_ge2),
        .wr_en   (wr_en),
        .wr_row  (coef_row_sel),
        .wr_c0   (coef_c0_col),
        .wr_c1   (coef_c1_col),
        .col_th1 (col_th1),
        .col_th2 (col_th2)
    );

    coinc_thr_select #(.NX(NX)) u_sel (
        .col_th1 (col_th1),
        .col_th2 (col_th2),
        .thr1    (thr1),
        .thr2    (thr2),
        .xpos    (xpos)
    );

endmodule

// File: rtl/coinc_array_chk.sv
module coinc_array_chk #(
    parameter int NX = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          thr1,
    input logic          thr2,
    input logic [NX-1:0] xpos,
    input logic [NX-1:0] col_th1,
    input logic [NX-1:0] col_th2,
    input logic          coef_wr,
    input logic          coef_rd,
    input logic [NX-1:0] rd_th1,
    input logic [NX-1:0] rd_th2
);
    AST_XPOS_PREFER_T2: assert property (@(posedge clk) disable iff (!rst_n)
        thr2 |-> (xpos == col_th2)); // R6
    AST_XPOS_FALLBACK_T1: assert property (@(posedge clk) disable iff (!rst_n)
        !thr2 |-> (xpos == col_th1)); // R6
    AST_NO_POS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (xpos == '0) |-> (!thr1 && !thr2)); // R5
    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_rd && !coef_wr) |=> (rd_th1 == $past(col_th1) && rd_th2 == $past(col_th2))); // R8
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(coef_rd && !coef_wr) |=> ($stable(rd_th1) && $stable(rd_th2))); // R9
endmodule

module coinc_matrix_chk
    import coinc_pkg::*;
#(
    parameter int NX = 8,
    parameter int NY = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [NY-1:0]          wr_row,
    input logic [NX-1:0]          wr_c0,
    input logic [NX-1:0]          wr_c1,
    input coef_t [NY-1:0][NX-1:0] cell_q
);
    coef_t [NX-1:0] row_exp;
    always_comb begin
        for (int i = 0; i < NX; i++) begin
            row_exp[i].c0 = wr_c0[i];
            row_exp[i].c1 = wr_c1[i];
        end
    end

    genvar r;
    generate
        for (r = 0; r < NY; r++) begin : g_rchk
            AST_ROW_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_row[r]) |=> (cell_q[r] == $past(row_exp))); // R7
            AST_ROW_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_row[r]) |=> $stable(cell_q[r])); // R7
        end
    endgenerate
endmodule

bind coinc_array coinc_array_chk #(.NX(NX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .thr1    (thr1),
    .thr2    (thr2),
    .xpos    (xpos),
    .col_th1 (col_th1),
    .col_th2 (col_th2),
    .coef_wr (coef_wr),
    .coef_rd (coef_rd),
    .rd_th1  (rd_th1),
    .rd_th2  (rd_th2)
);

bind coinc_matrix coinc_matrix_chk #(.NX(NX), .NY(NY)) u_mchk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_row (wr_row),
    .wr_c0  (wr_c0),
    .wr_c1  (wr_c1),
    .cell_q (cell_q)
);

// File: tb/coinc_array_tb.sv
module coinc_array_tb;
    localparam int NX = 8;
    localparam int NY = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_level;
    logic [NX-1:0] xa_in, xb_in, xa_mask, xb_mask;
    logic [NY-1:0] ya_in, yb_in, yc_in, ya_mask, yb_mask, yc_mask;
    logic coef_wr, coef_rd;
    logic [NY-1:0] coef_row_sel;
    logic [NX-1:0] coef_c0_col, coef_c1_col;
    logic thr1, thr2;
    logic [NX-1:0] xpos, rd_th1, rd_th2;

    int n_tests = 0;
    int n_fail  = 0;
    logic [NX-1:0] m_c0 [NY];
    logic [NX-1:0] m_c1 [NY];

    always #2 clk = ~clk;

    coinc_array #(.NX(NX), .NY(NY)) u_dut (.*);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected column vectors from R1..R4
    function automatic void model(output logic [NX-1:0] e1, output logic [NX-1:0] e2);
        logic [NX-1:0] xg1, xg2;
        logic [NY-1:0] yg1, yg2;
        int cnt;
        for (int i = 0; i < NX; i++) begin
            cnt = int'(xa_mask[i] ? mask_level : xa_in[i]) + int'(xb_mask[i] ? mask_level : xb_in[i]);
            xg1[i] = cnt >= 1; xg2[i] = cnt >= 2;
        end
        for (int j = 0; j < NY; j++) begin
            cnt = int'(ya_mask[j] ? mask_level : ya_in[j]) + int'(yb_mask[j] ? mask_level : yb_in[j])
                + int'(yc_mask[j] ? mask_level : yc_in[j]);
            yg1[j] = cnt >= 1; yg2[j] = cnt >= 2;
        end
        e1 = '0; e2 = '0;
        for (int j = 0; j < NY; j++)
            for (int i = 0; i < NX; i++)
                if ((xg2[i] && yg1[j]) || (xg1[i] && yg2[j])) begin
                    e1[i] = e1[i] | m_c0[j][i];
                    e2[i] = e2[i] | m_c1[j][i];
                end
    endfunction

    task automatic check_outputs(input string tag);
        logic [NX-1:0] e1, e2, ep;
        model(e1, e2);
        ep = (e2 != 0) ? e2 : e1;
        chk(thr1 == (e1 != 0), {tag, " R5 thr1"}, 32'(thr1), 32'(e1 != 0));
        chk(thr2 == (e2 != 0), {tag, " R5 thr2"}, 32'(thr2), 32'(e2 != 0));
        chk(xpos == ep, {tag, " R6 xpos"}, 32'(xpos), 32'(ep));
    endtask

    task automatic clear_inputs();
        mask_level = 0; xa_in = 0; xb_in = 0; ya_in = 0; yb_in = 0; yc_in = 0;
        xa_mask = 0; xb_mask = 0; ya_mask = 0; yb_mask = 0; yc_mask = 0;
    endtask

    task automatic do_write(input logic [NY-1:0] sel, input logic [NX-1:0] c0, input logic [NX-1:0] c1, input logic rd);
        @(negedge clk);
        coef_wr = 1; coef_rd = rd; coef_row_sel = sel; coef_c0_col = c0; coef_c1_col = c1;
        @(negedge clk);
        coef_wr = 0; coef_rd = 0;
        for (int j = 0; j < NY; j++)
            if (sel[j]) begin m_c0[j] = c0; m_c1[j] = c1; end
    endtask

    task automatic readback_row(input int j, input string tag);
        @(negedge clk);
        clear_inputs();
        xa_in = '1; xb_in = '1; ya_in = NY'(1) << j;
        coef_rd = 1;
        @(negedge clk);
        coef_rd = 0;
        #1;
        chk(rd_th1 == m_c0[j], {tag, " R8 rd_th1"}, 32'(rd_th1), 32'(m_c0[j]));
        chk(rd_th2 == m_c1[j], {tag, " R8 rd_th2"}, 32'(rd_th2), 32'(m_c1[j]));
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [NX-1:0] h1, h2;
        void'($urandom(32'd2468));
        for (int j = 0; j < NY; j++) begin m_c0[j] = 0; m_c1[j] = 0; end
        clear_inputs();
        coef_wr = 0; coef_rd = 0; coef_row_sel = 0; coef_c0_col = 0; coef_c1_col = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10: reset state, all inputs firing
        @(negedge clk);
        xa_in = '1; xb_in = '1; ya_in = '1; yb_in = '1; yc_in = '1;
        #1;
        chk(!thr1 && !thr2 && xpos == 0, "R10 flags after reset", {thr1, thr2, 22'd0, xpos}, 0);
        chk(rd_th1 == 0 && rd_th2 == 0, "R10 capture after reset", {rd_th1, rd_th2}, 0);

        // R7: random row writes, verified by readback
        for (int k = 0; k < 8; k++)
            do_write(NY'($urandom) & NY'($urandom), NX'($urandom), NX'($urandom), 0);
        for (int j = 0; j < NY; j++) readback_row(j, "R7 row load");

        // R7: empty row select changes nothing
        do_write('0, '1, '1, 0);
        for (int j = 0; j < NY; j += 5) readback_row(j, "R7 empty select");

        // R1..R6, R11: random combinational stimulus, sparse Y
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            mask_level = 1'($urandom);
            xa_in = NX'($urandom); xb_in = NX'($urandom);
            ya_in = NY'($urandom) & NY'($urandom); yb_in = NY'($urandom) & NY'($urandom);
            yc_in = NY'($urandom) & NY'($urandom);
            xa_mask = NX'($urandom) & NX'($urandom); xb_mask = NX'($urandom) & NX'($urandom);
            ya_mask = NY'($urandom) & NY'($urandom) & NY'($urandom);
            yb_mask = NY'($urandom) & NY'($urandom) & NY'($urandom);
            yc_mask = NY'($urandom) & NY'($urandom) & NY'($urandom);
            #1;
            check_outputs("R11 random");
        end

        // R3 boundary: X one hit, Y one hit (two of four) must not fire
        do_write(NY'(1), '1, '1, 0);
        @(negedge clk);
        clear_inputs();
        xa_in = 8'h01; ya_in = NY'(1);
        #1;
        chk(!thr1 && !thr2, "R3 two hits only", {thr1, thr2}, 0);
        yb_in = NY'(1);  // now three hits
        #1;
        chk(thr1 && thr2 && xpos == 8'h01, "R3 three hits", {thr1, thr2, 22'd0, xpos}, {2'b11, 22'd0, 8'h01});

        // R2: Y three hits with X one hit fires
        @(negedge clk);
        clear_inputs();
        xb_in = 8'h80; ya_in = NY'(1); yb_in = NY'(1); yc_in = NY'(1);
        #1;
        chk(xpos == 8'h80, "R2 Y count", 32'(xpos), 32'h80);

        // R4/R5/R6: thresholds differ per column, both flags, threshold 2 preferred
        do_write(NY'(2), 8'h0F, 8'h30, 0);
        @(negedge clk);
        clear_inputs();
        xa_in = '1; xb_in = '1; ya_in = NY'(2);
        #1;
        chk(thr1 && thr2, "R5 both flags", {thr1, thr2}, 2'b11);
        chk(xpos == 8'h30, "R6 prefer threshold 2", 32'(xpos), 32'h30);
        do_write(NY'(2), 8'h0F, 8'h00, 0);
        @(negedge clk);
        #1;
        chk(xpos == 8'h0F && !thr2, "R4 threshold 1 only", 32'(xpos), 32'h0F);

        // R1: masks to level 1 with inputs at 0
        @(negedge clk);
        clear_inputs();
        mask_level = 1; xa_mask = 8'h04; xb_mask = 8'h04; ya_mask = NY'(2);
        #1;
        chk(xpos == 8'h04, "R1 mask to one", 32'(xpos), 32'h04);
        mask_level = 0; xa_in = '1; xb_in = '1; ya_in = NY'(2); ya_mask = NY'(2);
        #1;
        chk(!thr1 && !thr2, "R1 mask to zero", {thr1, thr2}, 0);

        // R9: write and read together, capture must hold
        readback_row(1, "R9 prime");
        h1 = rd_th1; h2 = rd_th2;
        do_write(NY'(1) << 1, 8'hA5, 8'h5A, 1);
        #1;
        chk(rd_th1 == h1 && rd_th2 == h2, "R9 capture held", {rd_th1, rd_th2}, {h1, h2});
        readback_row(1, "R9 write done");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule